// File: doc/BRIEF.md
# Ramp Pattern Self-Test Generator and Checker

This block is a built-in self-test pair for an 8b/10b serial link. It works at the byte level, before encoding and after decoding. The generator side drives a character stream, an 8-bit byte plus a K flag. The stream is a byte ramp that counts up from 0x00 to 0xFF and wraps. An alignment comma, K28.5 (byte 0xBC with the K flag high), is placed in front of every group of 2^RAMP_CNT_BITS complete ramps, so that the far end can find character boundaries.

The checker side takes the decoded byte and K flag from the receive path. It hunts for the start of a ramp, which is the bytes 0x00, 0x01 and 0x02 arriving as data in consecutive enabled cycles. It then raises `chk_active`. From then on, every data byte must equal the previous data byte plus one, modulo 256. A mismatch raises `chk_err`, which stays high until the next comma. Characters with the K flag high are never compared.

Both halves share one clock and one synchronous reset, and each has its own enable. For an end-to-end test, the two halves are connected through the link. For a local test, the generator output can be looped straight into the checker.

The generator has two states:
- GEN_COMMA emits the comma and always moves to GEN_RAMP.
- GEN_RAMP emits the next ramp byte. It returns to GEN_COMMA after the 0xFF that ends the last ramp of a group.

The checker has four states, and every transition is taken only when `chk_en` is high:
- CHK_SEEK0 moves to CHK_SEEK1 on data 0x00.
- CHK_SEEK1 moves to CHK_SEEK2 on data 0x01, stays in CHK_SEEK1 on data 0x00, and otherwise returns to CHK_SEEK0.
- CHK_SEEK2 moves to CHK_LOCKED on data 0x02, returns to CHK_SEEK1 on data 0x00, and otherwise returns to CHK_SEEK0.
- CHK_LOCKED is left only through reset or through `chk_en` going low.

Top module: `ramp_bist`

## Requirements
- R1: While `rst` is high, and at the first clock edge with `rst` high, the generator drives `gen_k`=0 and `gen_data`=0x00, and the checker drives `chk_active`=0 and `chk_err`=0.
- R2: After reset, the first enabled generator cycle emits the comma: `gen_k`=1 and `gen_data`=0xBC. Every character with `gen_k`=1 carries 0xBC.
- R3: The character after a comma is data 0x00. After that, each enabled cycle emits the previous byte plus one with `gen_k`=0, wrapping from 0xFF to 0x00.
- R4: After exactly 256*2^RAMP_CNT_BITS ramp bytes, one comma is emitted. The ramp then resumes at 0x00.
- R5: While `gen_en` is low, `gen_k`, `gen_data` and the position in the pattern hold. The next enabled cycle emits the character that would have come next.
- R6: `chk_active` rises in the cycle after the checker samples data 0x02 that followed data 0x01 and data 0x00 in consecutive enabled cycles, all three with the K flag low.
- R7: A broken start sequence restarts the hunt. A data 0x00 begins a new attempt, and any K character or any other byte drops the attempt.
- R8: While active, a data byte that is not the previous data byte plus one (modulo 256, so 0xFF followed by 0x00 is correct) sets `chk_err` in the next cycle. `chk_err` then stays high through later bytes until a comma arrives.
- R9: A comma (`chk_k`=1 and `chk_data`=0xBC) sampled while enabled clears `chk_err` in the next cycle.
- R10: Characters with `chk_k`=1 are not compared. The data byte after them is compared against the last data byte seen before them. A K character other than 0xBC leaves `chk_err` unchanged.
- R11: `chk_en` low, or `rst` high, clears `chk_active`, `chk_err` and the hunt state in the next cycle.
- R12: `chk_err` is never high while `chk_active` is low. Out-of-sequence bytes during the hunt raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst | input | 1 | Synchronous reset, active high |
| gen_en | input | 1 | Generator advance enable |
| gen_k | output | 1 | Generator K flag |
| gen_data | output | 8 | Generator byte |
| chk_en | input | 1 | Checker enable; low clears the checker |
| chk_k | input | 1 | Received K flag |
| chk_data | input | 8 | Received byte |
| chk_active | output | 1 | Ramp start found |
| chk_err | output | 1 | Sequence error since the last comma |

## Verification
The bench walks one full comma period and looks for the comma at exactly the right position. A generator with a wrong ramp-group count or a wrong wrap would put the comma early or late. It also pauses the generator mid-ramp: a generator that kept counting while disabled would skip bytes on resume. On the checker side it sends start sequences broken by a wrong byte, a repeated 0x00 and an interleaved comma. A checker that did not restart the hunt correctly would lock falsely, or would fail to lock. It also places commas and other K characters between data bytes, crosses the 0xFF to 0x00 wrap, and confirms that the error holds until a comma. A checker that compared K characters, or forgot the last data byte, would then flag errors that should not exist or miss ones that should.

// File: rtl/ramp_bist_pkg.sv
package ramp_bist_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] COMMA_BYTE = 8'hBC;
    localparam logic [BYTE_W-1:0] START_B0   = 8'h00;
    localparam logic [BYTE_W-1:0] START_B1   = 8'h01;
    localparam logic [BYTE_W-1:0] START_B2   = 8'h02;

    typedef enum logic {
        GEN_COMMA,
        GEN_RAMP
    } gen_state_t;

    typedef enum logic [1:0] {
        CHK_SEEK0,
        CHK_SEEK1,
        CHK_SEEK2,
        CHK_LOCKED
    } chk_state_t;
endpackage

// File: rtl/ramp_gen.sv
module ramp_gen
    import ramp_bist_pkg::*;
#(
    parameter int RAMP_CNT_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic              k_o,
    output logic [BYTE_W-1:0] data_o
);
    gen_state_t st_q, st_d;
    logic [BYTE_W-1:0]        val_q;
    logic [RAMP_CNT_BITS-1:0] ramps_q;
    logic                     ramp_end;
    logic                     group_end;

    assign ramp_end  = (val_q == '1);
    assign group_end = ramp_end && (ramps_q == '1);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GEN_COMMA: st_d = GEN_RAMP;
            GEN_RAMP:  if (group_end) st_d = GEN_COMMA;
            default:   st_d = GEN_COMMA;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)     st_q <= GEN_COMMA;
        else if (en) st_q <= st_d;
    end

    // outputs and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            val_q   <= '0;
            ramps_q <= '0;
            k_o     <= 1'b0;
            data_o  <= '0;
        end else if (en) begin
            unique case (st_q)
                GEN_COMMA: begin
                    k_o    <= 1'b1;
                    data_o <= COMMA_BYTE;
                end
                GEN_RAMP: begin
                    k_o    <= 1'b0;
                    data_o <= val_q;
                    val_q  <= val_q + BYTE_W'(1);
                    if (ramp_end) ramps_q <= ramps_q + RAMP_CNT_BITS'(1);
                end
                default: begin
                    k_o    <= 1'b0;
                    data_o <= '0;
                end
            endcase
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r2_comma_code: assert property (@(posedge clk) disable iff (rst)
        k_o |-> data_o == COMMA_BYTE);

    a_r3_after_comma_zero: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(en) && $past(k_o) |-> !k_o && data_o == '0);

    a_r3_ramp_step: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(en) && !k_o && !$past(k_o) && $past(st_q) == GEN_RAMP
        |-> data_o == $past(data_o) + BYTE_W'(1));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(en) |-> $stable(k_o) && $stable(data_o));
endmodule

// File: rtl/ramp_chk.sv
module ramp_chk
    import ramp_bist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              k_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              active_o,
    output logic              err_o
);
    chk_state_t st_q, st_d;
    logic [BYTE_W-1:0] prev_q;
    logic              is_data;
    logic              is_comma;
    logic              clear;

    assign is_data  = !k_i;
    assign is_comma = k_i && (data_i == COMMA_BYTE);
    assign clear    = rst || !en;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CHK_SEEK0:
                if (is_data && data_i == START_B0) st_d = CHK_SEEK1;
            CHK_SEEK1:
                if (is_data && data_i == START_B1)      st_d = CHK_SEEK2;
                else if (is_data && data_i == START_B0) st_d = CHK_SEEK1;
                else                                    st_d = CHK_SEEK0;
            CHK_SEEK2:
                if (is_data && data_i == START_B2)      st_d = CHK_LOCKED;
                else if (is_data && data_i == START_B0) st_d = CHK_SEEK1;
                else                                    st_d = CHK_SEEK0;
            CHK_LOCKED: st_d = CHK_LOCKED;
            default:    st_d = CHK_SEEK0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (clear) st_q <= CHK_SEEK0;
        else       st_q <= st_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (clear) begin
            active_o <= 1'b0;
            err_o    <= 1'b0;
            prev_q   <= '0;
        end else begin
            active_o <= (st_d == CHK_LOCKED);
            if (is_data) prev_q <= data_i;
            if (st_q == CHK_LOCKED) begin
                if (is_comma) err_o <= 1'b0;
                else if (is_data && data_i != prev_q + BYTE_W'(1)) err_o <= 1'b1;
            end
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r12_err_needs_active: assert property (@(posedge clk) disable iff (rst)
        err_o |-> active_o);

    a_r9_comma_clears: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(en) && $past(is_comma) |-> !err_o);

    a_r11_disable_clears: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(en) |-> !active_o && !err_o);

    a_r6_lock_on_start: assert property (@(posedge clk) disable iff (rst)
        past_ok && $rose(active_o) |-> !$past(k_i) && $past(data_i) == START_B2);
endmodule

// File: rtl/ramp_bist.sv
module ramp_bist
    import ramp_bist_pkg::*;
#(
    parameter int RAMP_CNT_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_en,
    output logic              gen_k,
    output logic [BYTE_W-1:0] gen_data,
    input  logic              chk_en,
    input  logic              chk_k,
    input  logic [BYTE_W-1:0] chk_data,
    output logic              chk_active,
    output logic              chk_err
);
    ramp_gen #(.RAMP_CNT_BITS(RAMP_CNT_BITS)) u_gen (
        .clk    (clk),
        .rst    (rst),
        .en     (gen_en),
        .k_o    (gen_k),
        .data_o (gen_data)
    );

    ramp_chk u_chk (
        .clk      (clk),
        .rst      (rst),
        .en       (chk_en),
        .k_i      (chk_k),
        .data_i   (chk_data),
        .active_o (chk_active),
        .err_o    (chk_err)
    );
endmodule

// File: tb/ramp_bist_tb.sv
module ramp_bist_tb;
    localparam int RB = 2;
    localparam int PERIOD_BYTES = 256 * (1 << RB);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gen_en = 1'b0;
    logic       chk_en = 1'b0;
    logic       drv_k = 1'b0;
    logic [7:0] drv_data = 8'h00;
    logic       loop = 1'b0;
    logic       gen_k;
    logic [7:0] gen_data;
    logic       rx_k;
    logic [7:0] rx_data;
    logic       chk_active;
    logic       chk_err;
    int         n_checks = 0;
    int         n_fail = 0;

    assign rx_k    = loop ? gen_k : drv_k;
    assign rx_data = loop ? gen_data : drv_data;

    always #4 clk = ~clk;

    ramp_bist #(.RAMP_CNT_BITS(RB)) u_dut (
        .clk(clk), .rst(rst), .gen_en(gen_en), .gen_k(gen_k), .gen_data(gen_data),
        .chk_en(chk_en), .chk_k(rx_k), .chk_data(rx_data),
        .chk_active(chk_active), .chk_err(chk_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic k, input logic [7:0] d);
        drv_k = k;
        drv_data = d;
        step();
    endtask

    task automatic do_reset();
        rst = 1'b1; gen_en = 1'b0; chk_en = 1'b0; loop = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic chk_restart();
        chk_en = 1'b0; step(); chk_en = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check(gen_k == 1'b0 && gen_data == 8'h00, "R1 gen reset", {gen_k, gen_data}, 0);
        check(!chk_active && !chk_err, "R1 chk reset", {chk_active, chk_err}, 0);
    endtask

    task automatic t_gen_period();
        int bad = 0;
        do_reset();
        gen_en = 1'b1;
        step();
        check(gen_k && gen_data == 8'hBC, "R2 first comma", {gen_k, gen_data}, 9'h1BC);
        for (int i = 0; i < PERIOD_BYTES; i++) begin
            step();
            if (gen_k || gen_data != 8'(i)) begin
                if (bad == 0)
                    check(0, "R3 ramp byte", {gen_k, gen_data}, i % 256);
                bad++;
            end
        end
        check(bad == 0, "R3 ramp sequence", bad, 0);
        step();
        check(gen_k && gen_data == 8'hBC, "R4 periodic comma", {gen_k, gen_data}, 9'h1BC);
        step();
        check(!gen_k && gen_data == 8'h00, "R4 resume at 00", {gen_k, gen_data}, 0);
    endtask

    task automatic t_gen_pause();
        step(); step();
        check(!gen_k && gen_data == 8'h02, "R3 pre-pause", {gen_k, gen_data}, 2);
        gen_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            check(!gen_k && gen_data == 8'h02, "R5 hold while disabled", {gen_k, gen_data}, 2);
        end
        gen_en = 1'b1;
        step();
        check(!gen_k && gen_data == 8'h03, "R5 resume next", {gen_k, gen_data}, 3);
        gen_en = 1'b0;
    endtask

    task automatic t_chk_lock();
        do_reset();
        chk_en = 1'b1;
        send(0, 8'h00); send(0, 8'h01);
        check(!chk_active, "R6 not active before 02", chk_active, 0);
        send(0, 8'h02);
        check(chk_active && !chk_err, "R6 active after 00 01 02", {chk_active, chk_err}, 2);
    endtask

    task automatic t_chk_hunt();
        chk_restart();
        send(0, 8'h00); send(0, 8'h01); send(0, 8'h05); send(0, 8'h02);
        check(!chk_active, "R7 wrong byte drops attempt", chk_active, 0);
        send(0, 8'h00); send(1, 8'hBC); send(0, 8'h01); send(0, 8'h02);
        check(!chk_active, "R7 comma drops attempt", chk_active, 0);
        check(!chk_err, "R12 no error while hunting", chk_err, 0);
        send(0, 8'h00); send(0, 8'h00); send(0, 8'h01); send(0, 8'h02);
        check(chk_active, "R7 repeated 00 restarts attempt", chk_active, 1);
    endtask

    task automatic t_chk_err();
        send(0, 8'h03);
        check(!chk_err, "R8 correct step", chk_err, 0);
        send(0, 8'h05);
        check(chk_err, "R8 error on skip", chk_err, 1);
        send(0, 8'h06);
        check(chk_err, "R8 error sticky", chk_err, 1);
        send(1, 8'h1C);
        check(chk_err, "R10 other K leaves error", chk_err, 1);
        send(1, 8'hBC);
        check(!chk_err, "R9 comma clears error", chk_err, 0);
        send(0, 8'h07);
        check(!chk_err, "R10 compare across comma", chk_err, 0);
        send(1, 8'hBC);
        send(0, 8'h09);
        check(chk_err, "R10 skip across comma detected", chk_err, 1);
        send(1, 8'hBC);
        send(0, 8'hFF); send(1, 8'hBC); send(0, 8'h00);
        check(!chk_err && chk_active, "R8 wrap FF to 00", {chk_active, chk_err}, 2);
    endtask

    task automatic t_chk_disable();
        send(0, 8'h05);
        check(chk_err, "R8 error before disable", chk_err, 1);
        chk_en = 1'b0;
        send(0, 8'h06);
        check(!chk_active && !chk_err, "R11 disable clears", {chk_active, chk_err}, 0);
        chk_en = 1'b1;
        send(0, 8'h07); send(0, 8'h08);
        check(!chk_active, "R11 hunt restarted", chk_active, 0);
        send(0, 8'h00); send(0, 8'h01); send(0, 8'h02);
        check(chk_active, "R6 relock", chk_active, 1);
        rst = 1'b1;
        step();
        check(!chk_active && !chk_err, "R11 reset clears", {chk_active, chk_err}, 0);
        rst = 1'b0;
    endtask

    task automatic t_loopback();
        int errs = 0;
        do_reset();
        loop = 1'b1; gen_en = 1'b1; chk_en = 1'b1;
        for (int i = 0; i < PERIOD_BYTES + 300; i++) begin
            step();
            if (chk_err) errs++;
        end
        check(chk_active, "R6 loopback active", chk_active, 1);
        check(errs == 0, "R8 loopback no errors", errs, 0);
        loop = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_gen_period();
        t_gen_pause();
        t_chk_lock();
        t_chk_hunt();
        t_chk_err();
        t_chk_disable();
        t_loopback();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule